// File: doc/BRIEF.md
# Hardware Start Trigger Conditioner

This block turns a choice of hardware events into a one-cycle request that tells a scan sequencer to begin a conversion. Two event sources exist. The first is an asynchronous start pin, which is brought into the clock domain by a chain of flops and then judged by level or by edge. The second is a strobe from a PWM unit, where each strobe counts as one event. A software start input is merged in, so software and hardware are both ways to begin a conversion.

A master enable removes every hardware source and leaves only software start. The pin condition field selects one of four pin qualifiers. The field is a 2-bit code: bit 1 set means an edge mode and bit 1 clear means a level mode. In the level modes a new request is raised on every cycle that the level holds and the sequencer is idle. This gives back-to-back conversions for as long as the pin stays active. The configuration inputs are watched, so a change in them cannot be mistaken for a pin transition.

Top module: `trig_cond`

## Requirements
- R1: During reset and after it, `start_req` stays low until a software request or a qualified hardware event occurs.
- R2: A high `sw_start` in a cycle gives a high `start_req` in the next cycle, whatever the enable, source and busy inputs are.
- R3: With `hw_en`=1 and `src_sel`=1 (PWM source), every cycle with `pwm_evt` high gives one `start_req` pulse in the next cycle. `cond_sel`, `pin_raw` and `seq_busy` have no effect in this mode.
- R4: `pin_raw` passes through `SYNC_STAGES` flops (default 2) before it is judged. A pin-triggered request appears `SYNC_STAGES`+1 cycles after the pin input changes.
- R5: With `src_sel`=0 and `cond_sel`=3 (rising edge), each low-to-high transition of the pin gives exactly one `start_req` pulse, whatever `seq_busy` is. A falling transition gives none.
- R6: With `src_sel`=0 and `cond_sel`=2 (falling edge), each high-to-low transition of the pin gives exactly one pulse. A rising transition gives none.
- R7: With `src_sel`=0 and `cond_sel`=1 (high level), `start_req` is high in every cycle that follows a cycle in which the synchronised pin is high and `seq_busy` is low. It stays low while `seq_busy` is high or the pin is low.
- R8: With `src_sel`=0 and `cond_sel`=0 (low level), `start_req` is high in every cycle that follows a cycle in which the synchronised pin is low and `seq_busy` is low.
- R9: With `hw_en`=0, pin transitions and PWM strobes give no `start_req`.
- R10: A pin transition is not reported as an edge in these cases: it happened while the block was disabled or sourced from PWM, or its synchronised change falls in the same cycle as a change of `hw_en`, `src_sel` or `cond_sel`.
- R11: A software start and a hardware event in the same cycle give a single one-cycle `start_req` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_en | input | 1 | Enables hardware triggering |
| src_sel | input | 1 | 0 = start pin, 1 = PWM event strobe |
| cond_sel | input | 2 | Pin qualifier: 0 low level, 1 high level, 2 falling edge, 3 rising edge |
| pin_raw | input | 1 | Asynchronous external start pin |
| pwm_evt | input | 1 | Single-cycle PWM event strobe |
| seq_busy | input | 1 | Sequencer busy; blocks level-mode requests |
| sw_start | input | 1 | Software start request |
| start_req | output | 1 | One-cycle conversion start request |

## Verification
A software start and a hardware event can fall in the same cycle. The bench provokes this in two ways: it drives `sw_start` together with a PWM strobe, and it times `sw_start` to land in the cycle in which a synchronised rising pin edge is judged. In both cases the scoreboard expects exactly one pulse in the shared cycle. Any pulse in the following cycle is reported as unexpected.

// File: rtl/trig_cond_pkg.sv
package trig_cond_pkg;

   typedef enum logic [1:0] {
      PIN_LOW  = 2'd0,
      PIN_HIGH = 2'd1,
      PIN_FALL = 2'd2,
      PIN_RISE = 2'd3
   } pin_cond_e;

   typedef enum logic {
      SRC_PIN = 1'b0,
      SRC_PWM = 1'b1
   } trig_src_e;

   typedef struct packed {
      logic      en;
      trig_src_e src;
      pin_cond_e cond;
   } trig_cfg_t;

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("trig_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/trig_pin_qual.sv
module trig_pin_qual
   import trig_cond_pkg::*;
#(
   parameter logic IDLE_VAL = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  trig_cfg_t cfg,
   input  logic      pin_s,
   input  logic      seq_busy,
   output logic      pin_hit
);

   logic      prev_q;
   trig_cfg_t cfg_q;
   logic      cfg_same;
   logic      rise, fall;
   logic      hit_raw;
   logic      is_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= IDLE_VAL;
         cfg_q  <= '0;
      end else begin
         prev_q <= pin_s;
         cfg_q  <= cfg;
      end
   end

   assign cfg_same = (cfg == cfg_q);
   assign rise     = pin_s & ~prev_q;
   assign fall     = ~pin_s & prev_q;
   assign is_edge  = cfg.cond[1];

   always_comb begin
      unique case (cfg.cond)
         PIN_LOW:  hit_raw = ~pin_s & ~seq_busy;
         PIN_HIGH: hit_raw = pin_s & ~seq_busy;
         PIN_FALL: hit_raw = fall & cfg_same;
         PIN_RISE: hit_raw = rise & cfg_same;
         default:  hit_raw = 1'b0;
      endcase
   end

   assign pin_hit = cfg.en & (cfg.src == SRC_PIN) & hit_raw;

   // R5 / R6: an edge hit never repeats in the next cycle under the same setup
   a_r5_edge_once: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_hit && is_edge) |=> !(pin_hit && is_edge && $stable(cfg)));

   // R10: no edge reported in a cycle where the configuration moved
   a_r10_no_false_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (is_edge && !$stable(cfg)) |-> !pin_hit);

   // R7 / R8: busy sequencer blocks level requests
   a_r7_busy_blocks_level: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_edge && seq_busy) |-> !pin_hit);

endmodule

// File: rtl/trig_pulse_out.sv
module trig_pulse_out #(
   parameter bit REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic pulse
);

   generate
      if (REGISTERED) begin : g_reg
         logic pulse_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= req;
         end
         assign pulse = pulse_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign pulse = req;
      end
   endgenerate

endmodule

// File: rtl/trig_cond.sv
module trig_cond
   import trig_cond_pkg::*;
#(
   parameter int   SYNC_STAGES = 2,
   parameter logic PIN_IDLE    = 1'b0,
   parameter bit   OUT_REG     = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hw_en,
   input  logic       src_sel,
   input  logic [1:0] cond_sel,
   input  logic       pin_raw,
   input  logic       pwm_evt,
   input  logic       seq_busy,
   input  logic       sw_start,
   output logic       start_req
);

   localparam int PIN_LATENCY = SYNC_STAGES + (OUT_REG ? 1 : 0);

   generate
      if (PIN_LATENCY < 2) begin : g_bad_latency
         $error("trig_cond: synchroniser too shallow");
      end
   endgenerate

   trig_cfg_t cfg;
   logic      pin_s;
   logic      pin_hit;
   logic      pwm_hit;
   logic      req_any;

   assign cfg.en   = hw_en;
   assign cfg.src  = trig_src_e'(src_sel);
   assign cfg.cond = pin_cond_e'(cond_sel);

   trig_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_raw),
      .q     (pin_s)
   );

   trig_pin_qual #(
      .IDLE_VAL (PIN_IDLE)
   ) u_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg      (cfg),
      .pin_s    (pin_s),
      .seq_busy (seq_busy),
      .pin_hit  (pin_hit)
   );

   assign pwm_hit = hw_en & (cfg.src == SRC_PWM) & pwm_evt;
   assign req_any = sw_start | pwm_hit | pin_hit;

   trig_pulse_out #(
      .REGISTERED (OUT_REG)
   ) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_any),
      .pulse (start_req)
   );

   generate
      if (OUT_REG) begin : g_out_checks
         // R2: software start always yields a request one cycle on
         a_r2_sw_start: assert property (@(posedge clk) disable iff (!rst_n)
            sw_start |=> start_req);
         // R3: each PWM strobe yields a request one cycle on
         a_r3_pwm_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            (hw_en && src_sel && pwm_evt) |=> start_req);
         // R9: disabled hardware path stays silent without software start
         a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (!hw_en && !sw_start) |=> !start_req);
      end
   endgenerate

endmodule

// File: tb/tb_trig_cond.sv
module tb_trig_cond;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hw_en = 1'b0;
   logic       src_sel = 1'b0;
   logic [1:0] cond_sel = 2'd0;
   logic       pin_raw = 1'b0;
   logic       pwm_evt = 1'b0;
   logic       seq_busy = 1'b1;
   logic       sw_start = 1'b0;
   logic       start_req;

   trig_cond dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .hw_en     (hw_en),
      .src_sel   (src_sel),
      .cond_sel  (cond_sel),
      .pin_raw   (pin_raw),
      .pwm_evt   (pwm_evt),
      .seq_busy  (seq_busy),
      .sw_start  (sw_start),
      .start_req (start_req)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int    at;
      string req;
   } exp_t;

   exp_t  sb[$];
   string phase = "R1";
   int    checks = 0;
   int    failures = 0;
   bit    done = 1'b0;

   // monitor: pops expected pulses and compares with the output
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].at < cyc) begin
         checks++; failures++;
         $display("FAIL %s cycle %0d: actual=0 expected=1", sb[0].req, sb[0].at);
         void'(sb.pop_front());
      end
      if (start_req) begin
         checks++;
         if (sb.size() > 0 && sb[0].at == cyc) begin
            void'(sb.pop_front());
         end else begin
            failures++;
            $display("FAIL %s cycle %0d: actual=1 expected=0", phase, cyc);
         end
      end else if (sb.size() > 0 && sb[0].at == cyc) begin
         checks++; failures++;
         $display("FAIL %s cycle %0d: actual=0 expected=1", sb[0].req, cyc);
         void'(sb.pop_front());
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_at(input int at, input string r);
      exp_t e;
      e.at = at; e.req = r;
      sb.push_back(e);
   endtask

   task automatic check_quiet(input int n, input string r);
      int seen = 0;
      phase = r;
      for (int i = 0; i < n; i++) begin
         step(1);
         if (start_req) seen++;
      end
      checks++;
      if (seen != 0) begin
         failures++;
         $display("FAIL %s quiet window: actual=%0d expected=0", r, seen);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      int c;
      // R1: reset state
      step(3);
      checks++;
      if (start_req !== 1'b0) begin
         failures++;
         $display("FAIL R1 in reset: actual=%b expected=0", start_req);
      end
      rst_n = 1'b1;
      check_quiet(4, "R1");

      // R2: software start with hardware disabled
      phase = "R2";
      c = cyc; sw_start = 1'b1; expect_at(c + 1, "R2");
      step(1); sw_start = 1'b0; step(3);

      // R9: hardware disabled, PWM strobes and pin edges ignored
      src_sel = 1'b1; pwm_evt = 1'b1; phase = "R9";
      step(1); pwm_evt = 1'b0;
      src_sel = 1'b0; cond_sel = 2'd3; pin_raw = 1'b1;
      check_quiet(6, "R9");
      pin_raw = 1'b0; step(4);

      // R10: edge while disabled is not reported after enable
      pin_raw = 1'b1; step(5);
      hw_en = 1'b1;
      check_quiet(6, "R10");

      // R5: rising edge mode, falling ignored, busy ignored
      pin_raw = 1'b0;
      check_quiet(5, "R5");
      phase = "R5";
      c = cyc; pin_raw = 1'b1; expect_at(c + 3, "R5");
      step(8);
      pin_raw = 1'b0;
      check_quiet(6, "R5");
      // R4: latency of SYNC_STAGES+1 on a short high pulse
      phase = "R4";
      c = cyc; pin_raw = 1'b1; expect_at(c + 3, "R4");
      step(2); pin_raw = 1'b0; step(6);

      // R6: falling edge mode
      cond_sel = 2'd2; step(3);
      pin_raw = 1'b1;
      check_quiet(5, "R6");
      phase = "R6";
      c = cyc; pin_raw = 1'b0; expect_at(c + 3, "R6");
      step(8);

      // R10: pin moves while PWM sourced, then switch to pin
      src_sel = 1'b1; pin_raw = 1'b1; step(5);
      src_sel = 1'b0;
      check_quiet(5, "R10");
      // R10: synchronised fall lands in the cycle the source changes
      src_sel = 1'b1; step(3);
      c = cyc; pin_raw = 1'b0;
      step(2);
      src_sel = 1'b0;
      check_quiet(6, "R10");
      pin_raw = 1'b1; step(5);

      // R7: high level with busy gate
      cond_sel = 2'd1;
      check_quiet(4, "R7");
      phase = "R7";
      c = cyc; seq_busy = 1'b0;
      for (int k = 1; k <= 6; k++) expect_at(c + k, "R7");
      step(6); seq_busy = 1'b1;
      check_quiet(4, "R7");
      pin_raw = 1'b0; step(4); seq_busy = 1'b0;
      check_quiet(4, "R7");
      seq_busy = 1'b1;

      // R8: low level
      cond_sel = 2'd0;
      check_quiet(3, "R8");
      phase = "R8";
      c = cyc; seq_busy = 1'b0;
      for (int k = 1; k <= 4; k++) expect_at(c + k, "R8");
      step(4); seq_busy = 1'b1; step(1);
      // R4: level follows pin after the synchroniser delay
      seq_busy = 1'b0; phase = "R4";
      c = cyc; pin_raw = 1'b1;
      expect_at(c + 1, "R4"); expect_at(c + 2, "R4");
      step(6); seq_busy = 1'b1;

      // R3: PWM source, condition/pin/busy ignored
      pin_raw = 1'b0; step(4);
      src_sel = 1'b1; seq_busy = 1'b0;
      check_quiet(4, "R3");
      phase = "R3";
      c = cyc; pwm_evt = 1'b1; expect_at(c + 1, "R3");
      step(1); pwm_evt = 1'b0; step(3);
      c = cyc; pwm_evt = 1'b1; expect_at(c + 1, "R3"); expect_at(c + 2, "R3");
      step(2); pwm_evt = 1'b0; step(3);
      seq_busy = 1'b1;
      c = cyc; pwm_evt = 1'b1; expect_at(c + 1, "R3");
      step(1); pwm_evt = 1'b0; step(3);

      // R11: software start coincides with PWM strobe
      phase = "R11";
      c = cyc; pwm_evt = 1'b1; sw_start = 1'b1; expect_at(c + 1, "R11");
      step(1); pwm_evt = 1'b0; sw_start = 1'b0; step(3);
      // R11: software start coincides with a rising pin edge
      src_sel = 1'b0; cond_sel = 2'd3; step(3);
      c = cyc; pin_raw = 1'b1; expect_at(c + 3, "R11");
      step(2); sw_start = 1'b1;
      step(1); sw_start = 1'b0;
      step(5);

      checks++;
      if (sb.size() != 0) begin
         failures++;
         $display("FAIL %s leftover: actual=%0d expected=0", sb[0].req, sb.size());
      end
      finish_run();
   end

endmodule